// File: doc/BRIEF.md
# Per-Line Ownership Lockout Timer Table

A coherence controller that has just gained exclusive ownership of a cache line has to keep that line for a short window, so that its own stores can complete before another agent takes the line away. This block holds a small table of address-tagged deadlines for that purpose. The controller arms a deadline for a line address when exclusive data arrives. It may withdraw the deadline by address. At any time it can ask whether a given address is still inside its lockout window. While the answer is yes, the controller sends forwarded reads, forwarded ownership requests, DMA reads, invalidations and victim replacements for that line to the back of their queues. Processor loads and stores to the line still complete.

Each armed entry stores the line address and an absolute deadline, which is the value of a free-running cycle counter at the time of arming plus `LOCK_CYCLES`. The counter is only a few bits wider than the lockout window needs, and deadlines are compared as a signed distance, so wrap-around of the counter has no effect. When the counter reaches an entry's deadline, the block presents that address as a timeout event. The controller uses the event to move the line from its pending-exclusive or pending-modified state to the plain state. The entry frees itself in the same cycle. At most one timeout is presented per cycle. If more than one entry is due, the entry with the lowest slot index goes first.

Top module: `lockout_timer_table`

## Requirements
- R1: A set accepted in cycle k produces `expire_valid` with that address in cycle k+`LOCK_CYCLES` exactly, and not earlier.
- R2: `qry_locked` is high for an address from the cycle after its set up to and including the cycle in which its timeout is presented, and low from the following cycle on.
- R3: A clear that names an armed address disarms it: `qry_locked` for that address is low from the next cycle, and no timeout is ever presented for it. A clear that names an address not in the table has no effect on other entries.
- R4: At most one timeout is presented per cycle. When several entries are due, the lowest slot index is presented first and the others follow in later cycles. Each presented entry is freed.
- R5: A set to an address that is already armed replaces its deadline with the new cycle plus `LOCK_CYCLES` and does not occupy a second slot.
- R6: A set to an address that is not armed, made while all `ENTRIES` slots are armed, raises `set_full` in that same cycle and stores nothing. A set to an already-armed address is never refused.
- R7: After reset no address is locked, `expire_valid` is low and `set_full` is low.
- R8: When a set and a clear name the same address in the same cycle, the set takes effect and the address is locked from the next cycle.
- R9: A slot freed by a timeout can be reused by a later set to a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| set_valid | input | 1 | Arm or re-arm a lockout for `set_addr` in this cycle |
| set_addr | input | ADDR_W | Line address to lock |
| set_full | output | 1 | The set in this cycle was refused because every slot is armed |
| clr_valid | input | 1 | Withdraw the lockout of `clr_addr` |
| clr_addr | input | ADDR_W | Line address to unlock |
| qry_addr | input | ADDR_W | Line address being looked up |
| qry_locked | output | 1 | `qry_addr` currently holds an armed lockout |
| expire_valid | output | 1 | A lockout has reached its deadline in this cycle |
| expire_addr | output | ADDR_W | Address of the lockout that timed out |

## Verification
The bench uses a four-slot table with a six-cycle window and a small address pool, so that re-arms, full-table refusals and clears of absent addresses happen often. It checks the exact cycle of each timeout. A design that is off by one in the deadline, or that reads the deadline before the counter has moved, presents the timeout a cycle early or late. If a re-arm took a second slot, the table would report full one address too soon and would present a stale timeout. A clear that lost to a pending timeout, or a set that lost to a clear in the same cycle, shows up as a wrong lock answer in the next cycle. A freed slot that was never reclaimed shows up as a false `set_full`.

// File: rtl/lockout_pkg.sv
package lockout_pkg;

  parameter int unsigned LOCK_DEFAULT = 50;

  // Counter width: the largest signed distance seen is the lockout window
  // plus the worst backlog of due entries, so one sign bit on top suffices.
  function automatic int unsigned cnt_width(input int unsigned lock, input int unsigned n);
    return $clog2(lock + n + 1) + 1;
  endfunction

endpackage

// File: rtl/lockout_pick.sv
module lockout_pick #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign any = |req;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)) else $error("grant not one-hot"); // R4
  AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0) else $error("grant without request"); // R4

endmodule

// File: rtl/lockout_entry.sv
module lockout_entry #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned LOCK   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  now_i,
  input  logic              load_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              clr_valid_i,
  input  logic [ADDR_W-1:0] clr_addr_i,
  input  logic [ADDR_W-1:0] qry_addr_i,
  output logic              armed_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              set_match_o,
  output logic              qry_match_o,
  output logic              due_o
);

  logic              armed_q, armed_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  dl_q, dl_d;
  logic [CNT_W-1:0]  gap;
  logic              clr_hit;
  logic              en;

  assign clr_hit = clr_valid_i & armed_q & (addr_q == clr_addr_i);

  always_comb begin
    armed_d = armed_q;
    addr_d  = addr_q;
    dl_d    = dl_q;
    en      = 1'b0;
    if (load_i) begin
      en      = 1'b1;
      armed_d = 1'b1;
      addr_d  = set_addr_i;
      dl_d    = now_i + CNT_W'(LOCK);
    end else if (clr_hit || pop_i) begin
      en      = 1'b1;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      addr_q  <= '0;
      dl_q    <= '0;
    end else if (en) begin
      armed_q <= armed_d;
      addr_q  <= addr_d;
      dl_q    <= dl_d;
    end
  end

  // Signed distance: non-negative once the counter has reached the deadline.
  assign gap         = now_i - dl_q;
  assign due_o       = armed_q & ~gap[CNT_W-1];
  assign armed_o     = armed_q;
  assign addr_o      = addr_q;
  assign set_match_o = armed_q & (addr_q == set_addr_i);
  assign qry_match_o = armed_q & (addr_q == qry_addr_i);

  AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> armed_o) else $error("load did not arm"); // R2
  AST_FRESH_NOT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !due_o) else $error("fresh entry already due"); // R1
  AST_POP_ONLY_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> due_o) else $error("pop of entry not due"); // R4
  AST_CLR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !load_i) |=> !armed_o) else $error("clear left entry armed"); // R3

endmodule

// File: rtl/lockout_timer_table.sv
module lockout_timer_table #(
  parameter int unsigned ENTRIES     = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LOCK_CYCLES = lockout_pkg::LOCK_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [ADDR_W-1:0] set_addr,
  output logic              set_full,
  input  logic              clr_valid,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_locked,
  output logic              expire_valid,
  output logic [ADDR_W-1:0] expire_addr
);

  localparam int unsigned CNT_W = lockout_pkg::cnt_width(LOCK_CYCLES, ENTRIES);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  // Free-running time base.
  logic [CNT_W-1:0] now_q, now_d;

  assign now_d = now_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) now_q <= '0;
    else          now_q <= now_d;
  end

  logic [ENTRIES-1:0] armed, set_match, qry_match, due, load, pop;
  logic [ENTRIES-1:0] free_gnt;
  logic               free_any, due_any, hit_any;
  logic [ADDR_W-1:0]  slot_addr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    lockout_entry #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .LOCK   (LOCK_CYCLES)
    ) i_entry (
      .clk         (clk),
      .rst_n       (rst_n_s),
      .now_i       (now_q),
      .load_i      (load[g]),
      .pop_i       (pop[g]),
      .set_addr_i  (set_addr),
      .clr_valid_i (clr_valid),
      .clr_addr_i  (clr_addr),
      .qry_addr_i  (qry_addr),
      .armed_o     (armed[g]),
      .addr_o      (slot_addr[g]),
      .set_match_o (set_match[g]),
      .qry_match_o (qry_match[g]),
      .due_o       (due[g])
    );
  end

  lockout_pick #(.N(ENTRIES)) i_free_pick (
    .clk (clk),
    .rst_n (rst_n_s),
    .req (~armed),
    .gnt (free_gnt),
    .any (free_any)
  );

  lockout_pick #(.N(ENTRIES)) i_due_pick (
    .clk (clk),
    .rst_n (rst_n_s),
    .req (due),
    .gnt (pop),
    .any (due_any)
  );

  assign hit_any = |set_match;

  always_comb begin
    load = '0;
    if (set_valid) begin
      if (hit_any) load = set_match;
      else         load = free_gnt;
    end
  end

  assign set_full     = set_valid & ~hit_any & ~free_any;
  assign qry_locked   = |qry_match;
  assign expire_valid = due_any;

  always_comb begin
    expire_addr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      expire_addr = expire_addr | (slot_addr[i] & {ADDR_W{pop[i]}});
    end
  end

  AST_FULL_ALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n_s)
    set_full |-> (&armed)) else $error("full with a free slot"); // R6
  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(load)) else $error("set wrote more than one slot"); // R5
  AST_EXPIRE_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n_s)
    expire_valid |-> ($countones(pop & armed) == 1)) else $error("timeout without armed slot"); // R4

endmodule

// File: tb/test_lockout_timer_table.sv
module test_lockout_timer_table;

  localparam int unsigned N    = 4;
  localparam int unsigned AW   = 8;
  localparam int unsigned LOCK = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          set_valid, clr_valid;
  logic [AW-1:0] set_addr, clr_addr, qry_addr;
  logic          set_full, qry_locked, expire_valid;
  logic [AW-1:0] expire_addr;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  // Reference table
  bit          m_arm [N];
  logic [AW-1:0] m_adr [N];
  int          m_dl  [N];
  int          cyc = 0;

  always #10 clk = ~clk;

  lockout_timer_table #(
    .ENTRIES     (N),
    .ADDR_W      (AW),
    .LOCK_CYCLES (LOCK)
  ) i_lockout_timer_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_valid    (set_valid),
    .set_addr     (set_addr),
    .set_full     (set_full),
    .clr_valid    (clr_valid),
    .clr_addr     (clr_addr),
    .qry_addr     (qry_addr),
    .qry_locked   (qry_locked),
    .expire_valid (expire_valid),
    .expire_addr  (expire_addr)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic sv, input logic [AW-1:0] sa, input logic cv,
                      input logic [AW-1:0] ca, input logic [AW-1:0] qa, input string tag);
    int hit_i, free_i, due_i;
    bit e_full, e_lock;
    set_valid = sv; set_addr = sa;
    clr_valid = cv; clr_addr = ca;
    qry_addr  = qa;
    #5;
    hit_i = -1; free_i = -1; due_i = -1; e_lock = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (m_arm[i] && m_adr[i] == sa && hit_i < 0) hit_i = i;
      if (!m_arm[i] && free_i < 0) free_i = i;
      if (m_arm[i] && cyc >= m_dl[i] && due_i < 0) due_i = i;
      if (m_arm[i] && m_adr[i] == qa) e_lock = 1'b1;
    end
    e_full = sv && hit_i < 0 && free_i < 0;
    chk(tag, "set_full", 32'(set_full), 32'(e_full));
    chk(tag, "qry_locked", 32'(qry_locked), 32'(e_lock));
    chk(tag, "expire_valid", 32'(expire_valid), 32'(due_i >= 0));
    if (due_i >= 0) chk(tag, "expire_addr", 32'(expire_addr), 32'(m_adr[due_i]));
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      bit ld;
      ld = sv && ((hit_i == i) || (hit_i < 0 && free_i == i));
      if (ld) begin
        m_arm[i] = 1'b1; m_adr[i] = sa; m_dl[i] = cyc + LOCK;
      end else if ((cv && m_arm[i] && m_adr[i] == ca) || due_i == i) begin
        m_arm[i] = 1'b0;
      end
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [AW-1:0] qa, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, '0, 1'b0, '0, qa, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_arm[i] = 1'b0; m_adr[i] = '0; m_dl[i] = 0; end
    set_valid = 1'b0; clr_valid = 1'b0;
    set_addr = '0; clr_addr = '0; qry_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R7: idle after reset
    idle(2, 8'h00, "R7");

    // R1 and R2: single lockout, timeout exactly LOCK cycles later
    step(1'b1, 8'h11, 1'b0, '0, 8'h11, "R1");
    idle(LOCK - 1, 8'h11, "R2");
    step(1'b0, '0, 1'b0, '0, 8'h11, "R1");
    idle(3, 8'h11, "R2");

    // R3: clear before the deadline, then a clear of an absent address
    step(1'b1, 8'h22, 1'b0, '0, 8'h22, "R3");
    step(1'b0, '0, 1'b1, 8'h22, 8'h22, "R3");
    idle(LOCK + 2, 8'h22, "R3");
    step(1'b1, 8'h44, 1'b0, '0, 8'h44, "R3");
    step(1'b0, '0, 1'b1, 8'h33, 8'h44, "R3");
    idle(LOCK + 2, 8'h44, "R3");

    // R5: re-arm moves the deadline
    step(1'b1, 8'h55, 1'b0, '0, 8'h55, "R5");
    idle(3, 8'h55, "R5");
    step(1'b1, 8'h55, 1'b0, '0, 8'h55, "R5");
    idle(LOCK + 2, 8'h55, "R5");

    // R6: fill, refuse a new address, accept a re-arm; R9: reuse after timeout
    step(1'b1, 8'h01, 1'b0, '0, 8'h01, "R6");
    step(1'b1, 8'h02, 1'b0, '0, 8'h02, "R6");
    step(1'b1, 8'h03, 1'b0, '0, 8'h03, "R6");
    step(1'b1, 8'h04, 1'b0, '0, 8'h04, "R6");
    step(1'b1, 8'h05, 1'b0, '0, 8'h05, "R6");
    step(1'b1, 8'h02, 1'b0, '0, 8'h05, "R6");
    idle(LOCK + 4, 8'h02, "R9");
    step(1'b1, 8'h05, 1'b0, '0, 8'h05, "R9");
    step(1'b0, '0, 1'b0, '0, 8'h05, "R9");
    idle(LOCK + 2, 8'h05, "R9");

    // R8: set and clear of the same address in one cycle
    step(1'b1, 8'h66, 1'b1, 8'h66, 8'h66, "R8");
    idle(LOCK + 2, 8'h66, "R8");

    // R4: mixed traffic over a small address pool
    for (int k = 0; k < 3000; k++) begin
      logic sv, cv;
      sv = ($urandom % 3) == 0;
      cv = ($urandom % 6) == 0;
      step(sv, AW'($urandom % 6), cv, AW'($urandom % 6), AW'($urandom % 6), "R4");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule